// File: doc/BRIEF.md
# Watchdog Timer with Register Interface

A countdown watchdog for a system-on-chip. Software programs two 4-bit timeout selectors and then arms the counter. From then on it must write a fixed key value to a restart register at regular intervals. If the counter reaches the end of its period first, the block responds. In reset mode it pulses a system reset output. In interrupt mode it first raises an interrupt and reloads, and it pulses the reset only if a second period also runs out without a valid restart.

A selector value `s` gives a period of `2^(EXP_BASE+s)` clock cycles, with `EXP_BASE` = 16 on silicon. A testbench can lower `EXP_BASE` so that timeouts are reached quickly. The arming bit is sticky: software can set it but never clear it, and only the hardware reset `rst_ni` disarms the block. Access is through a simple single-cycle register port with 32-bit data and byte addresses of word-aligned registers. Read data is combinational.

Top module: `wdt_timer`

## Requirements
- R1: Register map by word index `addr_i[ADDR_W-1:2]`. Index 0 is control: bit 0 is arm, bit 1 is mode. Index 1 is timeout range: bits 3:0 hold the normal selector and bits 7:4 hold the initial selector, and both read back as written. Index 2 is the current count. Index 3 is restart.
- R2: Writing 1 to control bit 0 arms the watchdog. Writing 0 there is ignored, so arm stays 1 until `rst_ni` is asserted. Mode can be rewritten at any time.
- R3: The current count reads 0 while disarmed. While armed it decreases by one every clock. Writes to the count register have no effect.
- R4: The first countdown after arming lasts `2^(EXP_BASE+initial selector)` cycles, counted from the arming write edge to the expiry edge.
- R5: After an expiry, the next countdown lasts `2^(EXP_BASE+normal selector)` cycles.
- R6: Writing exactly 0x76 to restart while armed reloads the count to `2^(EXP_BASE+normal selector)-1` on that edge. Any other value, or any restart write while disarmed, leaves the count unchanged.
- R7: With mode = 0, every expiry drives `sys_rst_o` high for exactly `RST_CYCLES` cycles, starting on the expiry edge. `sys_rst_o` is only high while armed, and `irq_o` stays low.
- R8: With mode = 1, an expiry with no interrupt pending sets `irq_o` and reloads without a reset. An expiry with the interrupt pending starts the reset pulse instead. A valid restart clears `irq_o`.
- R9: Reads of word indices 4 and above return 0.
- R10: After reset, control, range and count read 0, and `irq_o` and `sys_rst_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (combinational, 0 when not reading) |
| irq_o | output | 1 | Pending expiry interrupt |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The bound checker watches every cycle for four things. It checks that arm never falls, that the count stays at zero while disarmed and steps down by one while armed, that the reset pulse never appears while disarmed, and that a valid restart clears the interrupt. It also checks that a reset pulse in interrupt mode follows a pending interrupt. The exact period lengths for each selector value, the pulse width, which selector governs the first countdown, and the register read-back values are shown only by the bench. It sweeps the selectors and times the outputs from a series of separate reset scenarios.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W  = 32;
  localparam int IDX_CTRL  = 0;
  localparam int IDX_RANGE = 1;
  localparam int IDX_COUNT = 2;
  localparam int IDX_KICK  = 3;
  localparam logic [DATA_W-1:0] KICK_KEY = 32'h0000_0076;

  typedef struct packed {
    logic       armed;
    logic       irq_mode;
  } wdt_ctrl_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int SEL_W  = 4,
  parameter int CNT_W  = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  count_i,
  output wdt_ctrl_t         ctrl_o,
  output logic [SEL_W-1:0]  top_o,
  output logic [SEL_W-1:0]  top_init_o,
  output logic              start_o,
  output logic              kick_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             wr, rd;
  wdt_ctrl_t        ctrl_q;
  logic [SEL_W-1:0] top_q, init_q;

  assign idx = addr_i[ADDR_W-1:2];
  assign wr  = req_i && we_i;
  assign rd  = req_i && !we_i;

  assign start_o = wr && (idx == IDX_W'(IDX_CTRL)) && wdata_i[0] && !ctrl_q.armed;
  assign kick_o  = wr && (idx == IDX_W'(IDX_KICK)) && (wdata_i == KICK_KEY) && ctrl_q.armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      top_q  <= '0;
      init_q <= '0;
    end else if (wr) begin
      if (idx == IDX_W'(IDX_CTRL)) begin
        ctrl_q.irq_mode <= wdata_i[1];
        if (wdata_i[0]) ctrl_q.armed <= 1'b1;  // sticky: clear ignored
      end
      if (idx == IDX_W'(IDX_RANGE)) begin
        top_q  <= wdata_i[SEL_W-1:0];
        init_q <= wdata_i[2*SEL_W-1:SEL_W];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      case (idx)
        IDX_W'(IDX_CTRL):  rdata_o = DATA_W'({ctrl_q.irq_mode, ctrl_q.armed});
        IDX_W'(IDX_RANGE): rdata_o = DATA_W'({init_q, top_q});
        IDX_W'(IDX_COUNT): rdata_o = DATA_W'(count_i);
        default:           rdata_o = '0;
      endcase
    end
  end

  assign ctrl_o     = ctrl_q;
  assign top_o      = top_q;
  assign top_init_o = init_q;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int SEL_W    = 4,
  parameter int EXP_BASE = 16,
  parameter int CNT_W    = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             armed_i,
  input  logic             start_i,
  input  logic             kick_i,
  input  logic [SEL_W-1:0] top_i,
  input  logic [SEL_W-1:0] top_init_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] period_m1(input logic [SEL_W-1:0] sel);
    logic [CNT_W:0] p;
    p = ({{CNT_W{1'b0}}, 1'b1} << (EXP_BASE + int'(sel))) - 1'b1;
    return p[CNT_W-1:0];
  endfunction

  assign expire_o = armed_i && !kick_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (start_i)                cnt_q <= period_m1(top_init_i);
    else if (armed_i) begin
      if (kick_i || cnt_q == '0)     cnt_q <= period_m1(top_i);
      else                           cnt_q <= cnt_q - 1'b1;
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/wdt_resp.sv
module wdt_resp #(
  parameter int RST_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_mode_i,
  input  logic expire_i,
  input  logic kick_i,
  output logic irq_o,
  output logic sys_rst_o
);
  localparam int PW = $clog2(RST_CYCLES + 1);

  logic          irq_q;
  logic [PW-1:0] pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q   <= 1'b0;
      pulse_q <= '0;
    end else begin
      if (pulse_q != '0) pulse_q <= pulse_q - 1'b1;
      if (kick_i) irq_q <= 1'b0;
      else if (expire_i) begin
        if (irq_mode_i && !irq_q) irq_q <= 1'b1;
        else                      pulse_q <= PW'(RST_CYCLES);
      end
    end
  end

  assign irq_o     = irq_q;
  assign sys_rst_o = (pulse_q != '0);
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int SEL_W      = 4,
  parameter int EXP_BASE   = 16,
  parameter int RST_CYCLES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              sys_rst_o
);
  localparam int CNT_W = EXP_BASE + (1 << SEL_W) - 1;

  wdt_ctrl_t        ctrl;
  logic [SEL_W-1:0] top, top_init;
  logic             start, kick, expire;
  logic [CNT_W-1:0] count;

  wdt_regs #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .count_i(count), .ctrl_o(ctrl), .top_o(top), .top_init_o(top_init),
    .start_o(start), .kick_o(kick)
  );

  wdt_counter #(.SEL_W(SEL_W), .EXP_BASE(EXP_BASE), .CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .armed_i(ctrl.armed), .start_i(start), .kick_i(kick),
    .top_i(top), .top_init_i(top_init), .count_o(count), .expire_o(expire)
  );

  wdt_resp #(.RST_CYCLES(RST_CYCLES)) u_resp (
    .clk_i, .rst_ni, .irq_mode_i(ctrl.irq_mode), .expire_i(expire),
    .kick_i(kick), .irq_o, .sys_rst_o
  );
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int CNT_W = 31
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             armed,
  input logic             mode,
  input logic             start,
  input logic             kick,
  input logic [CNT_W-1:0] count,
  input logic             irq_o,
  input logic             sys_rst_o
);
  AST_ARM_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |=> armed); // R2
  AST_CNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |-> count == '0); // R3
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !kick && !start && count != '0) |=> count == $past(count) - 1'b1); // R3
  AST_RST_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> armed); // R7
  AST_NO_IRQ_MODE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode && !irq_o) |=> !irq_o); // R7
  AST_KICK_CLR_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick |=> !irq_o); // R8
  AST_RST_AFTER_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sys_rst_o) && $past(mode)) |-> $past(irq_o)); // R8
endmodule

bind wdt_timer wdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .armed(ctrl.armed), .mode(ctrl.irq_mode), .start(start),
  .kick(kick), .count(count), .irq_o, .sys_rst_o
);

// File: tb/wdt_timer_tb.sv
module wdt_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int BASE   = 2;
  localparam int RSTC   = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq, sysrst;
  int          n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_timer #(.ADDR_W(ADDR_W), .EXP_BASE(BASE), .RST_CYCLES(RSTC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .sys_rst_o(sysrst)
  );

  task automatic chk(input bit ok, input string req_s, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req_s, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; req = 1'b0; we = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = ADDR_W'(a);
    #1 d = rdata; req = 1'b0;
  endtask

  // count posedges until sig == lvl (sampled just after edge), bounded
  task automatic edges_until(input bit use_irq, input bit lvl, output int n);
    n = 0;
    do begin
      @(posedge clk); #1 n++;
    end while (((use_irq ? irq : sysrst) != lvl) && n < 5000);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++; n_run++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n, w;
    do_reset();
    // R10 reset state
    rd(0, d); chk(d == 0, "R10 ctrl", d, 0);
    rd(4, d); chk(d == 0, "R10 range", d, 0);
    rd(8, d); chk(d == 0, "R10 count", d, 0);
    chk(!irq && !sysrst, "R10 outputs", {irq, sysrst}, 0);
    // R1 range readback, R9 undefined offsets
    wr(4, 32'h0000_00A5); rd(4, d); chk(d == 32'hA5, "R1 range", d, 32'hA5);
    for (int a = 16; a < 64; a += 4) begin
      rd(a, d); chk(d == 0, "R9 undefined", d, 0);
    end
    // R6 kick ignored while disarmed, R3 count 0
    wr(12, 32'h76); rd(8, d); chk(d == 0, "R6/R3 disarmed", d, 0);

    // R4 R5 R7 sweep in reset mode
    for (int s = 0; s < 6; s++) begin
      int t = 2 + (s % 3);
      do_reset();
      wr(4, (t << 4) == 0 ? 0 : ((s << 4) | t));
      wr(0, 32'h1);
      edges_until(1'b0, 1'b1, n);
      chk(n == (1 << (BASE + s)), $sformatf("R4 init sel %0d", s), n, 1 << (BASE + s));
      chk(!irq, "R7 no irq", irq, 0);
      edges_until(1'b0, 1'b0, w);
      chk(w == RSTC, "R7 pulse width", w, RSTC);
      edges_until(1'b0, 1'b1, n);
      chk(n + w == (1 << (BASE + t)), $sformatf("R5 top sel %0d", t), n + w, 1 << (BASE + t));
    end

    // R1 R2 R3 R6 register behaviour while armed
    do_reset();
    wr(4, 32'h0000_0053);            // init 5, top 3
    wr(0, 32'h1);
    rd(8, d); chk(d == (1 << (BASE + 5)) - 1, "R4 load", d, (1 << (BASE + 5)) - 1);
    wr(12, 32'h77);
    rd(8, d); chk(d == (1 << (BASE + 5)) - 2, "R6 wrong key", d, (1 << (BASE + 5)) - 2);
    wr(12, 32'h76);
    rd(8, d); chk(d == (1 << (BASE + 3)) - 1, "R6 reload", d, (1 << (BASE + 3)) - 1);
    wr(8, 32'h0);
    rd(8, d); chk(d == (1 << (BASE + 3)) - 2, "R3 count write", d, (1 << (BASE + 3)) - 2);
    wr(0, 32'h0);
    rd(0, d); chk(d == 32'h1, "R2 sticky", d, 1);
    wr(0, 32'h2);
    rd(0, d); chk(d == 32'h3, "R2 mode write", d, 3);
    rd(8, d); chk(d == (1 << (BASE + 3)) - 4, "R3 step", d, (1 << (BASE + 3)) - 4);

    // R8 interrupt mode
    do_reset();
    wr(4, 32'h0000_0012);            // init 1, top 2
    wr(0, 32'h3);
    edges_until(1'b1, 1'b1, n);
    chk(n == (1 << (BASE + 1)), "R8 first irq", n, 1 << (BASE + 1));
    chk(!sysrst, "R8 no reset on first", sysrst, 0);
    wr(12, 32'h76);
    chk(!irq, "R8 kick clears irq", irq, 0);
    edges_until(1'b1, 1'b1, n);
    chk(n == (1 << (BASE + 2)), "R8 irq after kick", n, 1 << (BASE + 2));
    edges_until(1'b0, 1'b1, n);
    chk(n == (1 << (BASE + 2)), "R8 second expiry reset", n, 1 << (BASE + 2));
    chk(irq, "R8 irq held", irq, 1);

    // R10 reset disarms
    do_reset();
    rd(0, d); chk(d == 0, "R10 rearm cleared", d, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule